// File: doc/BRIEF.md
# Cross-Domain Mailbox Register with Flag

This block carries one data word at a time from a write-clock domain to a read-clock domain. It sits beside a FIFO and does not use the FIFO storage. On the write side, a cycle that is enabled and has the mailbox select asserted stores the word. A flag in the write domain then drops and stays low until the reader has taken the word. While the flag is low, further mailbox writes are refused. This gives a one-deep handshake with write inhibit.

On the read side, the mailbox select input steers the output bus. When it is high, the bus shows the mailbox word. When it is low, the bus shows the FIFO output register. A qualified read of a pending word is sent back to the write domain as a toggle through a synchronizer, and that toggle raises the flag again. The read domain keeps its own copy of the word. It captures that copy when a new write toggle arrives, and the writer holds its register stable until the acknowledge comes back.

Top module: `mbox_xfer`

## Requirements
- R1: A write-clock rising edge with `wr_sel_n` low, `wr_en` high, `wr_mbox` high and `mbox_free` high stores `wr_data`, and `mbox_free` reads low after that edge.
- R2: While `mbox_free` is low, a write with all qualifiers is ignored. The word stored earlier is the one later delivered to the reader.
- R3: A qualified read of a pending word (`rd_sel_n` low, `rd_en` high, `rd_mbox` high on a read-clock rising edge) sets `mbox_free` high again within SYNC_STAGES+3 write-clock cycles. `mbox_free` never rises on the edge right after it falls.
- R4: After reset, `mbox_free` is high and the mailbox word seen on `rd_bus` is zero.
- R5: With `rd_mbox` high, `rd_bus` shows the latest mailbox word once SYNC_STAGES+1 read-clock edges have passed after the write. With `rd_mbox` low, `rd_bus` equals `fifo_q`.
- R6: A write cycle that lacks any one qualifier (`wr_sel_n` high, `wr_en` low, or `wr_mbox` low) stores nothing and leaves `mbox_free` high.
- R7: A read that lacks any one qualifier does not release the flag. `mbox_free` stays low.
- R8: A qualified mailbox read with no pending word returns the last stored word and leaves `mbox_free` unchanged. It also does not acknowledge a word written afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_sel_n | input | 1 | Write-port select, active low |
| wr_en | input | 1 | Write-port enable, active high |
| wr_mbox | input | 1 | Routes a write-port cycle to the mailbox |
| wr_data | input | DATA_W | Word to store |
| mbox_free | output | 1 | High when the mailbox accepts a write |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_sel_n | input | 1 | Read-port select, active low |
| rd_en | input | 1 | Read-port enable, active high |
| rd_mbox | input | 1 | Selects the mailbox (high) or the FIFO register (low) |
| fifo_q | input | DATA_W | FIFO output register contents |
| rd_bus | output | DATA_W | Read-port data bus |

## Verification
The bench writes a word and then tries a second write while the flag is low. A design without the write inhibit would overwrite the first word, and the reader would get the wrong value. Reads that lack one qualifier are issued while a word is pending. A design that ignored select or enable would release the flag, and the check on `mbox_free` would see it high. A qualified mailbox read with nothing pending is followed by a fresh write. A design that acknowledged that idle read would let the stale acknowledge raise the flag before the reader took the new word. The two clocks have unrelated periods, so a missing synchronizer stage or a capture on the wrong edge appears as a stale word on `rd_bus`.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int MBOX_DATA_W_DEF = 36;
    localparam int MBOX_SYNC_DEF   = 2;

    // handshake toggles held in the read domain
    typedef struct packed {
        logic seen;   // last write toggle observed
        logic ack;    // toggle returned to the writer
    } rd_hs_t;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mbox_wr_side.sv
module mbox_wr_side #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              en,
    input  logic              mbox,
    input  logic [DATA_W-1:0] data,
    input  logic              ack_sync,
    output logic              free,
    output logic              tog,
    output logic [DATA_W-1:0] word
);
    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              tog;
    } wr_state_t;

    wr_state_t state_d, state_q;
    logic      fire;

    always_comb begin
        state_d = state_q;
        free    = (state_q.tog == ack_sync);
        fire    = !sel_n && en && mbox && free;
        if (fire) begin
            state_d.word = data;
            state_d.tog  = ~state_q.tog;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign tog  = state_q.tog;
    assign word = state_q.word;
endmodule

// File: rtl/mbox_rd_side.sv
module mbox_rd_side
    import mbox_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              en,
    input  logic              mbox,
    input  logic              tog_sync,
    input  logic [DATA_W-1:0] wr_word,
    input  logic [DATA_W-1:0] fifo_q,
    output logic              ack,
    output logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] bus
);
    typedef struct packed {
        logic [DATA_W-1:0] word;
        rd_hs_t            hs;
    } rd_state_t;

    rd_state_t state_d, state_q;
    logic      arrive, pending, fire;

    always_comb begin
        state_d      = state_q;
        arrive       = (tog_sync != state_q.hs.seen);
        pending      = (state_q.hs.seen != state_q.hs.ack);
        fire         = !sel_n && en && mbox && pending;
        state_d.hs.seen = tog_sync;
        if (arrive) state_d.word = wr_word;   // writer holds it until ack returns
        if (fire)   state_d.hs.ack = ~state_q.hs.ack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign ack  = state_q.hs.ack;
    assign word = state_q.word;
    assign bus  = mbox ? state_q.word : fifo_q;
endmodule

// File: rtl/mbox_xfer.sv
module mbox_xfer
    import mbox_pkg::*;
#(
    parameter int DATA_W      = MBOX_DATA_W_DEF,
    parameter int SYNC_STAGES = MBOX_SYNC_DEF
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_sel_n,
    input  logic              wr_en,
    input  logic              wr_mbox,
    input  logic [DATA_W-1:0] wr_data,
    output logic              mbox_free,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_sel_n,
    input  logic              rd_en,
    input  logic              rd_mbox,
    input  logic [DATA_W-1:0] fifo_q,
    output logic [DATA_W-1:0] rd_bus
);
    logic              wr_tog_w, wr_tog_rs_w;
    logic              rd_ack_w, rd_ack_ws_w;
    logic [DATA_W-1:0] mbox_word_w, rd_word_w;

    mbox_wr_side #(.DATA_W(DATA_W)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .sel_n(wr_sel_n), .en(wr_en),
        .mbox(wr_mbox), .data(wr_data), .ack_sync(rd_ack_ws_w),
        .free(mbox_free), .tog(wr_tog_w), .word(mbox_word_w)
    );

    mbox_sync #(.STAGES(SYNC_STAGES)) u_tog_sync (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_tog_w), .q(wr_tog_rs_w)
    );

    mbox_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_ack_w), .q(rd_ack_ws_w)
    );

    mbox_rd_side #(.DATA_W(DATA_W)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .sel_n(rd_sel_n), .en(rd_en),
        .mbox(rd_mbox), .tog_sync(wr_tog_rs_w), .wr_word(mbox_word_w),
        .fifo_q(fifo_q), .ack(rd_ack_w), .word(rd_word_w), .bus(rd_bus)
    );
endmodule

// File: rtl/mbox_xfer_chk.sv
module mbox_xfer_chk #(
    parameter int DATA_W = 36
) (
    input logic              wr_clk,
    input logic              wr_rst_n,
    input logic              wr_sel_n,
    input logic              wr_en,
    input logic              wr_mbox,
    input logic              mbox_free,
    input logic [DATA_W-1:0] mbox_word,
    input logic              rd_clk,
    input logic              rd_rst_n,
    input logic              rd_mbox,
    input logic [DATA_W-1:0] fifo_q,
    input logic [DATA_W-1:0] rd_bus
);
    a_r1_write_clears_flag: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (!wr_sel_n && wr_en && wr_mbox && mbox_free) |=> !mbox_free);

    a_r2_word_held_while_busy: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !mbox_free |=> $stable(mbox_word));

    a_r3_no_instant_release: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $fell(mbox_free) |=> !mbox_free);

    a_r6_idle_keeps_flag: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (mbox_free && !(!wr_sel_n && wr_en && wr_mbox)) |=> mbox_free);

    a_r5_fifo_path: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !rd_mbox |-> rd_bus == fifo_q);

    always_comb begin
        if (!wr_rst_n) begin
            a_r4_flag_reset: assert (mbox_free);
        end
    end
endmodule

bind mbox_xfer mbox_xfer_chk #(.DATA_W(DATA_W)) u_chk (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_sel_n(wr_sel_n), .wr_en(wr_en),
    .wr_mbox(wr_mbox), .mbox_free(mbox_free), .mbox_word(mbox_word_w),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_mbox(rd_mbox),
    .fifo_q(fifo_q), .rd_bus(rd_bus)
);

// File: tb/mbox_xfer_test.sv
module mbox_xfer_test;
    localparam int  W        = 36;
    localparam time WR_PER   = 10ns;
    localparam time RD_PER   = 14ns;
    localparam int  SETTLE_W = 6;   // > SYNC_STAGES+3 write cycles
    localparam int  SETTLE_R = 5;   // > SYNC_STAGES+1 read cycles

    logic         wr_clk = 0, rd_clk = 0;
    logic         wr_rst_n = 0, rd_rst_n = 0;
    logic         wr_sel_n = 1, wr_en = 0, wr_mbox = 0;
    logic [W-1:0] wr_data = '0;
    logic         rd_sel_n = 1, rd_en = 0, rd_mbox = 0;
    logic [W-1:0] fifo_q = 36'h0_5A5A_1234;
    logic         mbox_free;
    logic [W-1:0] rd_bus;

    int checks = 0, failures = 0;
    logic [W-1:0] exp_q[$];
    logic [W-1:0] last_word = '0;

    mbox_xfer uut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_sel_n(wr_sel_n), .wr_en(wr_en),
        .wr_mbox(wr_mbox), .wr_data(wr_data), .mbox_free(mbox_free),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_sel_n(rd_sel_n), .rd_en(rd_en),
        .rd_mbox(rd_mbox), .fifo_q(fifo_q), .rd_bus(rd_bus)
    );

    always #(WR_PER/2) wr_clk = ~wr_clk;
    always #(RD_PER/2) rd_clk = ~rd_clk;

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: one write-port cycle; scoreboard gets the word when it is stored
    task automatic wr_op(input logic sel_n, input logic en, input logic mb,
                         input logic [W-1:0] d, input bit stores);
        @(negedge wr_clk);
        wr_sel_n = sel_n; wr_en = en; wr_mbox = mb; wr_data = d;
        @(negedge wr_clk);
        wr_sel_n = 1; wr_en = 0; wr_mbox = 0;
        if (stores) begin
            exp_q.push_back(d);
            last_word = d;
        end
    endtask

    // monitor: one read-port cycle, compares the bus with the scoreboard head
    task automatic rd_op(input string req, input logic sel_n, input logic en,
                         input bit take);
        logic [W-1:0] exp;
        repeat (SETTLE_R) @(negedge rd_clk);
        rd_sel_n = sel_n; rd_en = en; rd_mbox = 1;
        #1;
        if (take) exp = exp_q.pop_front();
        else      exp = last_word;
        check(req, rd_bus, exp);
        @(negedge rd_clk);
        rd_sel_n = 1; rd_en = 0; rd_mbox = 0;
    endtask

    task automatic flag_after(input string req, input logic exp);
        repeat (SETTLE_W) @(negedge wr_clk);
        check(req, {35'd0, mbox_free}, {35'd0, exp});
    endtask

    initial begin
        #(WR_PER * 20000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge rd_clk);
        // R4: reset state
        check("R4 flag", {35'd0, mbox_free}, 36'd1);
        rd_mbox = 1; #1;
        check("R4 word", rd_bus, '0);
        rd_mbox = 0; #1;
        check("R5 fifo path", rd_bus, fifo_q);
        wr_rst_n = 1; rd_rst_n = 1;

        // R1: store and flag drop
        wr_op(0, 1, 1, 36'h1_2345_6789, 1);
        check("R1 flag low", {35'd0, mbox_free}, 36'd0);
        // R2: blocked overwrite
        wr_op(0, 1, 1, 36'hF_FFFF_0000, 0);
        check("R2 flag still low", {35'd0, mbox_free}, 36'd0);
        // R5 + R2: reader gets the first word
        rd_op("R2/R5 mbox word", 0, 1, 1);
        flag_after("R3 flag released", 1);

        // R7: unqualified reads keep flag low
        wr_op(0, 1, 1, 36'hA_BCDE_F012, 1);
        rd_op("R7 peek sel_n high", 1, 1, 0);
        rd_op("R7 peek en low", 0, 0, 0);
        flag_after("R7 flag held", 0);
        rd_op("R7 real read", 0, 1, 1);
        flag_after("R3 flag released", 1);

        // R6: writes missing a qualifier
        wr_op(1, 1, 1, 36'h0_DEAD_0001, 0);
        wr_op(0, 0, 1, 36'h0_DEAD_0002, 0);
        wr_op(0, 1, 0, 36'h0_DEAD_0003, 0);
        check("R6 flag high", {35'd0, mbox_free}, 36'd1);
        // R8: idle read returns last word, flag unchanged
        rd_op("R6/R8 last word", 0, 1, 0);
        flag_after("R8 flag unchanged", 1);
        // R8: idle read does not pre-ack the next word
        wr_op(0, 1, 1, 36'h7_0F0F_3C3C, 1);
        flag_after("R8 no stale ack", 0);
        rd_op("R8 new word", 0, 1, 1);
        flag_after("R3 flag released", 1);

        // R5: several data patterns, fifo path in between
        for (int i = 0; i < 6; i++) begin
            logic [W-1:0] d;
            d = {4'(i), 32'h1357_9BDF ^ (32'h1111_1111 * i)};
            wr_op(0, 1, 1, d, 1);
            fifo_q = ~d;
            @(negedge rd_clk); #1;
            check("R5 fifo path", rd_bus, fifo_q);
            rd_op("R5 pattern", 0, 1, 1);
            flag_after("R3 pattern release", 1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule